// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is one DMA channel that works through a circular ring of 128-bit descriptors kept in a local descriptor store. Software fills ring entries through a write port, then moves the head index forward to give those entries to the engine. The engine reads the entry at its tail index and decodes the type nibble. A copy entry becomes a request on a memory-move port carrying source, destination and a byte count. A status entry becomes a 64-bit write request to an address and may also raise an interrupt.

Entries complete strictly in ring order. The tail index goes up by one only when the request for the current entry is acknowledged, so software may treat every entry before the tail as finished. Two faults stop the channel. The first is rewriting the head with the value it already holds, which counts as overrunning the whole ring. The second is an entry whose type code is not known. A fault is held in an error register until the channel is disabled. That register has its own mask on the summary error output. While the channel is disabled or halted, a quiesce flag is high.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset the tail index is 0, both request outputs and `irq` are low, `err_flags` is 0, and `quiesce` is high while `chan_en` is low.
- R2: An entry whose bits 127:124 equal 1 produces `cp_req`. The fields are `cp_src` from bits 45:0, `cp_dst` from bits 109:64, and `cp_bytes` equal to the 14-bit field at bits 59:46 multiplied by 64. The request and its fields stay steady until `cp_ack`.
- R3: An entry whose bits 127:124 equal 2 produces `st_req`, with `st_data` from bits 63:0 and `st_addr` from bits 109:64, held until `st_ack`.
- R4: Entries are served one at a time in ring order. The tail index advances by exactly one for each acknowledged request and never otherwise. No request is made while the tail equals the head.
- R5: When a status entry has bit 123 set, `irq` pulses for one cycle in the cycle after its acknowledge, unless `irq_mask` is high.
- R6: While enabled, a head write of the value the head already holds sets `err_flags` bit 0. It also raises `chan_err` and `quiesce`, and no further entry is started.
- R7: An entry with a type code other than 1 or 2 sets `err_flags` bit 1 and makes no request, and the tail stays on that entry. Disabling the channel clears `err_flags`, and re-enabling resumes at the tail.
- R8: `chan_err` is the OR of the `err_flags` bits that are not set in `err_mask`. `err_flags` itself is not masked.
- R9: Ring indices wrap from RING_DEPTH-1 to 0.
- R10: While `chan_en` is low, no entry is started and `quiesce` is high, but head writes are still taken and acted on once the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_en | input | 1 | Channel enable; low clears the error register |
| irq_mask | input | 1 | Suppresses interrupt pulses |
| err_mask | input | 2 | Per-bit mask of `chan_err` |
| dw_en | input | 1 | Descriptor store write strobe |
| dw_idx | input | IDX_W | Ring entry to write |
| dw_data | input | 128 | Entry contents, second word in bits 127:64 |
| head_wr | input | 1 | Head index write strobe |
| head_val | input | IDX_W | New head index |
| tail_idx | output | IDX_W | Completion index |
| cp_req | output | 1 | Copy request |
| cp_src | output | ADDR_W | Copy source address |
| cp_dst | output | ADDR_W | Copy destination address |
| cp_bytes | output | LEN_W+ALIGN_SH | Copy length in bytes |
| cp_ack | input | 1 | Copy done |
| st_req | output | 1 | Status write request |
| st_addr | output | ADDR_W | Status write address |
| st_data | output | 64 | Status write data |
| st_ack | input | 1 | Status write done |
| irq | output | 1 | Interrupt pulse |
| err_flags | output | 2 | Bit 0 head overrun, bit 1 bad type |
| chan_err | output | 1 | Masked error summary |
| quiesce | output | 1 | Channel disabled or halted |

## Verification
The assertions assume that `cp_ack` and `st_ack` are high only for one cycle while the matching request is high. They also assume that software does not rewrite the entry at the tail while it is waiting to be started. The bench's responder process drives each acknowledge only after it has seen the matching request at a falling edge, and it drops the acknowledge one cycle later with a varying latency. Descriptors are always written before the head moves past them. The one exception is entries that are deliberately rewritten while the channel is halted or disabled.

// File: rtl/desc_ring_engine.sv
module desc_ring_engine #(
  parameter int RING_DEPTH = 128,
  parameter int ADDR_W     = 46,
  parameter int LEN_W      = 14,
  parameter int ALIGN_SH   = 6,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int BYTES_W   = LEN_W + ALIGN_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic               irq_mask,
  input  logic [1:0]         err_mask,
  input  logic               dw_en,
  input  logic [IDX_W-1:0]   dw_idx,
  input  logic [127:0]       dw_data,
  input  logic               head_wr,
  input  logic [IDX_W-1:0]   head_val,
  output logic [IDX_W-1:0]   tail_idx,
  output logic               cp_req,
  output logic [ADDR_W-1:0]  cp_src,
  output logic [ADDR_W-1:0]  cp_dst,
  output logic [BYTES_W-1:0] cp_bytes,
  input  logic               cp_ack,
  output logic               st_req,
  output logic [ADDR_W-1:0]  st_addr,
  output logic [63:0]        st_data,
  input  logic               st_ack,
  output logic               irq,
  output logic [1:0]         err_flags,
  output logic               chan_err,
  output logic               quiesce
);
  localparam int LEN_LSB = 46;
  localparam logic [3:0] T_COPY = 4'd1;
  localparam logic [3:0] T_STAT = 4'd2;

  logic [127:0]     ring [RING_DEPTH];
  logic [IDX_W-1:0] head_q, tail_q;
  logic [1:0]       err_q;
  logic             int_q;

  always_ff @(posedge clk)
    if (dw_en) ring[dw_idx] <= dw_data;

  wire [127:0] cur      = ring[tail_q];
  wire [3:0]   cur_type = cur[127:124];
  wire         busy     = cp_req | st_req;
  wire         run      = chan_en & (err_q == 2'b00);
  wire         issue    = run & ~busy & (tail_q != head_q);
  wire         unused_bits = ^{cur[63:60], cur[122:64+ADDR_W], cur[59-LEN_W+1+LEN_LSB-46 +: 0+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= '0;
      tail_q   <= '0;
      err_q    <= '0;
      int_q    <= 1'b0;
      irq      <= 1'b0;
      cp_req   <= 1'b0;
      cp_src   <= '0;
      cp_dst   <= '0;
      cp_bytes <= '0;
      st_req   <= 1'b0;
      st_addr  <= '0;
      st_data  <= '0;
    end else begin
      irq <= 1'b0;
      if (head_wr) head_q <= head_val;
      if (!chan_en) err_q <= 2'b00;
      else begin
        if (head_wr && head_val == head_q) err_q[0] <= 1'b1;
        if (issue && cur_type != T_COPY && cur_type != T_STAT) err_q[1] <= 1'b1;
      end
      if (issue && cur_type == T_COPY) begin
        cp_req   <= 1'b1;
        cp_src   <= cur[ADDR_W-1:0];
        cp_dst   <= cur[64 +: ADDR_W];
        cp_bytes <= {cur[LEN_LSB +: LEN_W], {ALIGN_SH{1'b0}}};
      end
      if (issue && cur_type == T_STAT) begin
        st_req  <= 1'b1;
        st_data <= cur[63:0];
        st_addr <= cur[64 +: ADDR_W];
        int_q   <= cur[123];
      end
      if (cp_req && cp_ack) begin
        cp_req <= 1'b0;
        tail_q <= tail_q + 1'b1;
      end
      if (st_req && st_ack) begin
        st_req <= 1'b0;
        tail_q <= tail_q + 1'b1;
        irq    <= int_q & ~irq_mask;
      end
    end
  end

  assign tail_idx  = tail_q;
  assign err_flags = err_q;
  assign chan_err  = |(err_q & ~err_mask);
  assign quiesce   = ~run;
endmodule

module desc_ring_engine_chk #(
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 46
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              irq_mask,
  input logic [IDX_W-1:0]  tail_idx,
  input logic              cp_req,
  input logic [ADDR_W-1:0] cp_src,
  input logic              cp_ack,
  input logic              st_req,
  input logic              st_ack,
  input logic              irq,
  input logic [1:0]        err_flags,
  input logic              quiesce
);
  assert_req_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cp_req && st_req));
  assert_cp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req && !cp_ack) |=> (cp_req && $stable(cp_src)));
  assert_tail_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !((cp_req && cp_ack) || (st_req && st_ack)) |=> $stable(tail_idx));
  assert_tail_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cp_req && cp_ack) || (st_req && st_ack)) |=> (tail_idx == $past(tail_idx) + 1'b1));
  assert_irq_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(st_req && st_ack) && !$past(irq_mask)));
  assert_err_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != 2'b00 && !cp_req && !st_req) |=> (!cp_req && !st_req));
  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> quiesce);
endmodule

bind desc_ring_engine desc_ring_engine_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .irq_mask(irq_mask),
  .tail_idx(tail_idx), .cp_req(cp_req), .cp_src(cp_src), .cp_ack(cp_ack),
  .st_req(st_req), .st_ack(st_ack), .irq(irq), .err_flags(err_flags),
  .quiesce(quiesce));

// File: tb/desc_ring_engine_bench.sv
module desc_ring_engine_bench;
  localparam int IDX_W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_en = 0, irq_mask = 0, dw_en = 0, head_wr = 0, cp_ack = 0, st_ack = 0;
  logic [1:0] err_mask = 0;
  logic [IDX_W-1:0] dw_idx = 0, head_val = 0;
  logic [127:0] dw_data = 0;
  logic [IDX_W-1:0] tail_idx;
  logic cp_req, st_req, irq, chan_err, quiesce;
  logic [45:0] cp_src, cp_dst, st_addr;
  logic [19:0] cp_bytes;
  logic [63:0] st_data;
  logic [1:0] err_flags;

  desc_ring_engine u_desc_ring_engine (.*);

  always #2.5 clk = ~clk;

  typedef struct packed {logic k; logic [45:0] a; logic [63:0] b; logic [19:0] n;} exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0, irq_cnt = 0, resp_cnt = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      summary();
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq) irq_cnt++;
  end

  initial forever begin
    @(negedge clk);
    if (cp_req || st_req) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected request", {63'd0, cp_req}, 0);
        e = '0;
      end else e = exp_q.pop_front();
      if (cp_req) begin
        check(e.k == 1'b0, "R2 kind", 0, e.k);
        check(cp_src == e.a, "R2 src", cp_src, e.a);
        check(cp_dst == e.b[45:0], "R2 dst", cp_dst, e.b[45:0]);
        check(cp_bytes == e.n, "R2 bytes", cp_bytes, e.n);
      end else begin
        check(e.k == 1'b1, "R3 kind", 1, e.k);
        check(st_addr == e.a, "R3 addr", st_addr, e.a);
        check(st_data == e.b, "R3 data", st_data, e.b);
      end
      repeat (resp_cnt % 3) @(negedge clk);
      resp_cnt++;
      if (cp_req) cp_ack = 1; else st_ack = 1;
      @(negedge clk);
      cp_ack = 0;
      st_ack = 0;
    end
  end

  task automatic put(input int idx, input logic [127:0] d);
    @(negedge clk);
    dw_en = 1; dw_idx = idx[IDX_W-1:0]; dw_data = d;
    @(negedge clk);
    dw_en = 0;
  endtask

  task automatic put_copy(input int idx, input logic [45:0] s, input logic [45:0] d, input logic [13:0] l);
    exp_t e;
    put(idx, {4'h1, 14'd0, d, 4'h0, l, s});
    e.k = 0; e.a = s; e.b = {18'd0, d}; e.n = {l, 6'd0};
    exp_q.push_back(e);
  endtask

  task automatic put_stat(input int idx, input logic [45:0] a, input logic [63:0] v, input bit ir);
    exp_t e;
    put(idx, {4'h2, ir, 13'd0, a, v});
    e.k = 1; e.a = a; e.b = v; e.n = 0;
    exp_q.push_back(e);
  endtask

  task automatic set_head(input int v);
    @(negedge clk);
    head_wr = 1; head_val = v[IDX_W-1:0];
    @(negedge clk);
    head_wr = 0;
  endtask

  task automatic wait_tail(input int v, input string tag);
    for (int i = 0; i < 3000 && tail_idx != v[IDX_W-1:0]; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(tail_idx == v[IDX_W-1:0], tag, tail_idx, v);
  endtask

  initial begin
    int irq0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(tail_idx == 0, "R1 tail", tail_idx, 0);
    check(!cp_req && !st_req && !irq, "R1 outputs", {cp_req, st_req, irq}, 0);
    check(err_flags == 0, "R1 err", err_flags, 0);
    check(quiesce == 1, "R1 quiesce", quiesce, 1);

    put_copy(0, 46'h123456, 46'h2000, 14'd3);
    set_head(1);
    repeat (10) @(negedge clk);
    check(resp_cnt == 0 && tail_idx == 0, "R10 disabled idle", resp_cnt, 0);
    check(quiesce == 1, "R10 quiesce", quiesce, 1);
    chan_en = 1;
    wait_tail(1, "R10 head kept, R2 copy done");
    check(quiesce == 0, "R1 quiesce low when running", quiesce, 0);

    irq0 = irq_cnt;
    put_stat(1, 46'h3000, 64'hDEAD_BEEF_0123_4567, 1);
    put_copy(2, 46'h4000, 46'h5000, 14'h3FFF);
    put_stat(3, 46'h6000, 64'h1, 0);
    set_head(4);
    wait_tail(4, "R4 mixed in order");
    check(irq_cnt == irq0 + 1, "R5 one irq pulse", irq_cnt, irq0 + 1);
    check(exp_q.size() == 0, "R4 all served", exp_q.size(), 0);

    irq_mask = 1;
    irq0 = irq_cnt;
    put_stat(4, 46'h7000, 64'h55, 1);
    set_head(5);
    wait_tail(5, "R5 masked tail");
    check(irq_cnt == irq0, "R5 masked irq", irq_cnt, irq0);
    irq_mask = 0;

    for (int i = 5; i < 131; i++) put_copy(i % 128, 46'(i * 64), 46'(i * 128 + 7), 14'(i));
    set_head(3);
    wait_tail(3, "R9 wrap");
    check(exp_q.size() == 0, "R9 wrap all served", exp_q.size(), 0);

    set_head(3);
    repeat (2) @(negedge clk);
    check(err_flags == 2'b01, "R6 err bit0", err_flags, 1);
    check(chan_err == 1 && quiesce == 1, "R6 chan_err quiesce", {chan_err, quiesce}, 3);
    put_copy(3, 46'h8000, 46'h9000, 14'd1);
    set_head(4);
    repeat (10) @(negedge clk);
    check(tail_idx == 3 && resp_cnt > 0, "R6 halted", tail_idx, 3);
    err_mask = 2'b01;
    @(negedge clk);
    check(chan_err == 0, "R8 masked", chan_err, 0);
    check(err_flags == 2'b01, "R8 flags kept", err_flags, 1);
    err_mask = 0;
    chan_en = 0;
    @(negedge clk);
    @(negedge clk);
    check(err_flags == 0, "R7 disable clears", err_flags, 0);
    chan_en = 1;
    wait_tail(4, "R6 resume after re-enable");

    put(4, {4'h5, 60'd0, 64'd0});
    set_head(5);
    repeat (8) @(negedge clk);
    check(err_flags == 2'b10, "R7 bad type", err_flags, 2);
    check(tail_idx == 4 && !cp_req && !st_req, "R7 tail held", tail_idx, 4);
    put_copy(4, 46'hA000, 46'hB000, 14'd2);
    chan_en = 0;
    @(negedge clk);
    chan_en = 1;
    wait_tail(5, "R7 resume");
    check(err_flags == 0 && exp_q.size() == 0, "R7 clean", err_flags, 0);
    summary();
  end
endmodule